// File: doc/BRIEF.md
# Compressed Cache Set Tag and Segment Manager

This block keeps the tags and the segment allocation for one set of a compressed cache. The set has four tags, but its data area only holds two uncompressed 64-byte lines. The data area is a pool of sixteen 8-byte segments. Each tag records an address tag, a permission field, a compressed flag and a size in segments. Tags are kept apart from data, so a tag can stay valid after the data of its line has been evicted. A lookup that matches such a tag is still a miss, but it tells the caller where the tag sits in the recency order. That lets an outside policy count misses that compression would have avoided.

Resident lines are packed with no gaps, most recently used first. A line's first segment is therefore the total size of the resident lines that are more recent than it. The controller runs three states:

- `ST_IDLE`: accepts requests. A lookup is answered on the next cycle and the state stays `ST_IDLE`. An accepted fill moves to `ST_EVICT`.
- `ST_EVICT`: drops the data of the least recently used resident line, one line per cycle, until the free segments cover the new line. It then moves to `ST_PLACE`.
- `ST_PLACE`: writes the new tag, returns the response and goes back to `ST_IDLE`.

The compression engine and the decision whether to compress are outside this block.

Top module: `cset_ctrl`

## Requirements
- R1: After reset every tag is invalid, `req_ready` is 1, and any lookup returns hit 0, found 0 and all other response fields 0.
- R2: A lookup is accepted when `req_valid` and `req_ready` are both 1 with `req_fill`=0. The response comes on the next cycle. For a tag whose data is resident it gives hit 1, found 1 and the stored compressed flag, permission and size. It also gives the recency position, where 0 is the most recently used and 3 the least.
- R3: A lookup that matches a valid tag whose data is absent gives hit 0, found 1, the position, the stored flag, permission and size, and start 0.
- R4: A lookup that matches no valid tag gives hit 0, found 0 and all other fields 0, and changes no tag, no data and no recency order.
- R5: The effective size of a fill is 8 segments when `req_comp`=0, or when `req_size` is 0 or greater than 8. Otherwise it is `req_size`. A line stored with flag 0 always reports size 8.
- R6: The start segment reported on a hit is the sum of the sizes of the resident lines at more recent positions.
- R7: Before placing a fill, the block evicts resident data, least recently used first, until the free segments are at least the effective size. It evicts no more than that. The sum of the resident sizes never exceeds 16.
- R8: A fill reuses the tag that matches `req_tag`. With no match it takes the lowest-numbered invalid tag. Failing that it reclaims the least recently used tag. The old data of the chosen tag is dropped first.
- R9: A lookup that finds a tag, and every fill, moves that tag to position 0. The tags that were more recent than it each move down by one, and the order always stays a permutation of the four tags.
- R10: A fill response gives hit 0 and found equal to whether the tag was already valid. It gives position 0, start 0, and the effective size, flag and permission.
- R11: From the acceptance of a fill until its response, `req_ready` is 0. `rsp_valid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_fill | input | 1 | 1 = fill, 0 = lookup |
| req_tag | input | 12 | Address tag |
| req_perm | input | 2 | Permission bits stored on fill |
| req_comp | input | 1 | 1 = line is compressed |
| req_size | input | 4 | Compressed size in segments |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Line data resident |
| rsp_tag_found | output | 1 | A valid tag matched |
| rsp_lru_pos | output | 2 | Recency position of the matched tag (0 = newest) |
| rsp_comp | output | 1 | Stored compressed flag |
| rsp_perm | output | 2 | Stored permission bits |
| rsp_size | output | 4 | Stored size in segments |
| rsp_start | output | 5 | First segment of the line |

## Verification
The bench drives a pseudo-random sweep of fills and lookups over a pool of six tags. The pool is larger than the four tags the set can hold, so tags get reclaimed. Sizes cover 0 through 15, and both compressed and uncompressed lines are used. After every fill the bench looks up every tag in the pool and compares each field against a model computed in the bench.

The eviction loop is the main target. A design that evicts one line too many shows up as an extra tag-only miss. One that evicts the most recent line instead of the least recent gives the wrong hit pattern. A design that forgets to drop a reused tag's old data gives a wrong start segment.

Reports of absent-data tags are checked because a design could wrongly treat them as unknown tags. Missing size normalisation would produce a 3-segment uncompressed line. Recency shuffling is checked through every position report that follows.

// File: rtl/cset_pkg.sv
package cset_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_PLACE = 2'd2
    } cset_state_e;
endpackage

// File: rtl/cset_lru.sv
module cset_lru #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  touch_en,
    input  logic [IW-1:0]         touch_idx,
    output logic [N-1:0][IW-1:0]  order
);
    logic [N-1:0][IW-1:0] order_nxt;
    logic [IW-1:0]        hit_pos;
    logic [N-1:0]         seen;

    always_comb begin
        hit_pos = IW'(N - 1);
        for (int p = 0; p < N; p++)
            if (order[p] == touch_idx) hit_pos = IW'(p);
        order_nxt    = order;
        order_nxt[0] = touch_idx;
        for (int p = 1; p < N; p++)
            if (p <= int'(hit_pos)) order_nxt[p] = order[p-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < N; p++) order[p] <= IW'(p);
        end else if (touch_en) begin
            order <= order_nxt;
        end
    end

    always_comb begin
        seen = '0;
        for (int p = 0; p < N; p++) seen[order[p]] = 1'b1;
    end

    // R9
    lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) &seen);
    // R9
    mru_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> order[0] == $past(touch_idx));
endmodule

// File: rtl/cset_layout.sv
module cset_layout #(
    parameter int N  = 4,
    parameter int IW = 2,
    parameter int SW = 4,
    parameter int PW = 5
) (
    input  logic [N-1:0][IW-1:0] order,
    input  logic [N-1:0]         present,
    input  logic [N-1:0][SW-1:0] size,
    input  logic [IW-1:0]        target,
    output logic [N-1:0][PW-1:0] start,
    output logic [N-1:0][IW-1:0] pos,
    output logic [PW:0]          used,
    output logic [IW-1:0]        victim,
    output logic                 victim_ok
);
    logic [PW:0] run;

    always_comb begin
        run       = '0;
        start     = '0;
        pos       = '0;
        victim    = '0;
        victim_ok = 1'b0;
        for (int p = 0; p < N; p++) begin
            pos[order[p]]   = IW'(p);
            start[order[p]] = run[PW-1:0];
            if (present[order[p]]) begin
                run = run + (PW+1)'(size[order[p]]);
                if (order[p] != target) begin
                    victim    = order[p];
                    victim_ok = 1'b1;
                end
            end
        end
        used = run;
    end
endmodule

// File: rtl/cset_ctrl.sv
module cset_ctrl
    import cset_pkg::*;
#(
    parameter int NUM_TAGS  = 4,
    parameter int NUM_SEGS  = 16,
    parameter int LINE_SEGS = 8,
    parameter int TAG_W     = 12,
    parameter int PERM_W    = 2,
    parameter int IDX_W     = $clog2(NUM_TAGS),
    parameter int SIZE_W    = $clog2(LINE_SEGS + 1),
    parameter int POS_W     = $clog2(NUM_SEGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_fill,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [PERM_W-1:0] req_perm,
    input  logic              req_comp,
    input  logic [SIZE_W-1:0] req_size,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_tag_found,
    output logic [IDX_W-1:0]  rsp_lru_pos,
    output logic              rsp_comp,
    output logic [PERM_W-1:0] rsp_perm,
    output logic [SIZE_W-1:0] rsp_size,
    output logic [POS_W-1:0]  rsp_start
);
    localparam logic [SIZE_W-1:0] FULL = SIZE_W'(LINE_SEGS);

    cset_state_e st, st_nxt;

    logic [NUM_TAGS-1:0]              ent_valid, ent_present, ent_comp;
    logic [NUM_TAGS-1:0][TAG_W-1:0]   ent_tag;
    logic [NUM_TAGS-1:0][PERM_W-1:0]  ent_perm;
    logic [NUM_TAGS-1:0][SIZE_W-1:0]  ent_size;

    logic [IDX_W-1:0]  f_idx;
    logic [SIZE_W-1:0] f_size;
    logic [TAG_W-1:0]  f_tag;
    logic [PERM_W-1:0] f_perm;
    logic              f_comp, f_found;

    logic [NUM_TAGS-1:0][IDX_W-1:0] order;
    logic [NUM_TAGS-1:0][POS_W-1:0] lay_start;
    logic [NUM_TAGS-1:0][IDX_W-1:0] lay_pos;
    logic [POS_W:0]                 used;
    logic [IDX_W-1:0]               victim, touch_idx, match_idx, free_idx, claim_idx;
    logic                           victim_ok, touch_en, match_ok, free_ok;
    logic                           take_look, take_fill, room_ok;
    logic [SIZE_W-1:0]              eff_size;

    cset_lru #(.N(NUM_TAGS), .IW(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
        .touch_idx(touch_idx), .order(order)
    );

    cset_layout #(.N(NUM_TAGS), .IW(IDX_W), .SW(SIZE_W), .PW(POS_W)) u_lay (
        .order(order), .present(ent_present), .size(ent_size), .target(f_idx),
        .start(lay_start), .pos(lay_pos), .used(used),
        .victim(victim), .victim_ok(victim_ok)
    );

    assign req_ready = (st == ST_IDLE);
    assign take_look = req_ready && req_valid && !req_fill;
    assign take_fill = req_ready && req_valid && req_fill;
    assign room_ok   = (NUM_SEGS - int'(used)) >= int'(f_size);
    assign eff_size  = (!req_comp || req_size == '0 || req_size > FULL) ? FULL : req_size;
    assign touch_en  = (take_look && match_ok) || (st == ST_PLACE);
    assign touch_idx = (st == ST_PLACE) ? f_idx : match_idx;
    assign claim_idx = match_ok ? match_idx : (free_ok ? free_idx : order[NUM_TAGS-1]);

    always_comb begin
        match_ok  = 1'b0;
        match_idx = '0;
        free_ok   = 1'b0;
        free_idx  = '0;
        for (int i = 0; i < NUM_TAGS; i++)
            if (ent_valid[i] && ent_tag[i] == req_tag) begin
                match_ok  = 1'b1;
                match_idx = IDX_W'(i);
            end
        for (int i = NUM_TAGS - 1; i >= 0; i--)
            if (!ent_valid[i]) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (take_fill) st_nxt = ST_EVICT;
            ST_EVICT: if (room_ok)   st_nxt = ST_PLACE;
            ST_PLACE: st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0; ent_present <= '0; ent_comp <= '0;
            ent_tag <= '0; ent_perm <= '0; ent_size <= '0;
            f_idx <= '0; f_size <= '0; f_tag <= '0; f_perm <= '0;
            f_comp <= 1'b0; f_found <= 1'b0;
            rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_tag_found <= 1'b0;
            rsp_lru_pos <= '0; rsp_comp <= 1'b0; rsp_perm <= '0;
            rsp_size <= '0; rsp_start <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (take_look) begin
                        rsp_valid     <= 1'b1;
                        rsp_tag_found <= match_ok;
                        rsp_hit       <= match_ok && ent_present[match_idx];
                        rsp_lru_pos   <= match_ok ? lay_pos[match_idx] : '0;
                        rsp_comp      <= match_ok && ent_comp[match_idx];
                        rsp_perm      <= match_ok ? ent_perm[match_idx] : '0;
                        rsp_size      <= match_ok ? ent_size[match_idx] : '0;
                        rsp_start     <= (match_ok && ent_present[match_idx]) ?
                                         lay_start[match_idx] : '0;
                    end else if (take_fill) begin
                        f_idx    <= claim_idx;
                        f_size   <= eff_size;
                        f_tag    <= req_tag;
                        f_perm   <= req_perm;
                        f_comp   <= req_comp;
                        f_found  <= match_ok;
                        ent_valid[claim_idx]   <= 1'b0;
                        ent_present[claim_idx] <= 1'b0;
                    end
                end
                ST_EVICT: begin
                    if (!room_ok && victim_ok) ent_present[victim] <= 1'b0;
                end
                ST_PLACE: begin
                    ent_valid[f_idx]   <= 1'b1;
                    ent_present[f_idx] <= 1'b1;
                    ent_tag[f_idx]     <= f_tag;
                    ent_perm[f_idx]    <= f_perm;
                    ent_comp[f_idx]    <= f_comp;
                    ent_size[f_idx]    <= f_size;
                    rsp_valid     <= 1'b1;
                    rsp_hit       <= 1'b0;
                    rsp_tag_found <= f_found;
                    rsp_lru_pos   <= '0;
                    rsp_comp      <= f_comp;
                    rsp_perm      <= f_perm;
                    rsp_size      <= f_size;
                    rsp_start     <= '0;
                end
                default: ;
            endcase
        end
    end

    // R7
    segs_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(used) <= NUM_SEGS);
    // R2
    hit_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> rsp_tag_found);
    // R5
    uncomp_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && !rsp_comp) |-> rsp_size == FULL);
    // R6
    start_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (int'(rsp_start) + int'(rsp_size)) <= NUM_SEGS);
    // R11
    fill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_fill |=> (!req_ready && !rsp_valid));
endmodule

// File: tb/cset_ctrl_test.sv
module cset_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_fill = 1'b0, req_comp = 1'b0;
    logic [11:0] req_tag = '0;
    logic [1:0]  req_perm = '0;
    logic [3:0]  req_size = '0;
    logic        req_ready, rsp_valid, rsp_hit, rsp_tag_found, rsp_comp;
    logic [1:0]  rsp_lru_pos, rsp_perm;
    logic [3:0]  rsp_size;
    logic [4:0]  rsp_start;

    int vectors = 0, fails = 0;
    bit done = 0;

    int m_valid[4], m_pres[4], m_tag[4], m_perm[4], m_comp[4], m_size[4], m_ord[4];

    always #5 clk = ~clk;

    cset_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_fill(req_fill), .req_tag(req_tag), .req_perm(req_perm),
        .req_comp(req_comp), .req_size(req_size), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_tag_found(rsp_tag_found), .rsp_lru_pos(rsp_lru_pos),
        .rsp_comp(rsp_comp), .rsp_perm(rsp_perm), .rsp_size(rsp_size),
        .rsp_start(rsp_start)
    );

    function automatic int pos_of(int i);
        for (int p = 0; p < 4; p++) if (m_ord[p] == i) return p;
        return 3;
    endfunction

    function automatic void touch(int i);
        int p = pos_of(i);
        for (int q = p; q > 0; q--) m_ord[q] = m_ord[q-1];
        m_ord[0] = i;
    endfunction

    function automatic int used_segs();
        int s = 0;
        for (int i = 0; i < 4; i++) if (m_pres[i] != 0) s += m_size[i];
        return s;
    endfunction

    function automatic int start_of(int i);
        int s = 0;
        for (int j = 0; j < 4; j++)
            if (m_pres[j] != 0 && pos_of(j) < pos_of(i)) s += m_size[j];
        return s;
    endfunction

    function automatic int find(int t);
        for (int i = 0; i < 4; i++) if (m_valid[i] != 0 && m_tag[i] == t) return i;
        return -1;
    endfunction

    task automatic check_one(string lbl, int t, int h, int f, int p, int c, int pm, int sz, int st);
        vectors++;
        if (rsp_valid !== 1'b1 || int'(rsp_hit) != h || int'(rsp_tag_found) != f ||
            int'(rsp_lru_pos) != p || int'(rsp_comp) != c || int'(rsp_perm) != pm ||
            int'(rsp_size) != sz || int'(rsp_start) != st) begin
            fails++;
            $display("FAIL %s tag=%0d got v%0d h%0d f%0d p%0d c%0d pm%0d s%0d st%0d exp v1 h%0d f%0d p%0d c%0d pm%0d s%0d st%0d",
                lbl, t, rsp_valid, rsp_hit, rsp_tag_found, rsp_lru_pos, rsp_comp, rsp_perm,
                rsp_size, rsp_start, h, f, p, c, pm, sz, st);
        end
    endtask

    task automatic flag(string lbl, bit ok, int got, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0d exp %0d", lbl, got, exp);
        end
    endtask

    task automatic issue(bit fill, int t, int pm, bit c, int sz);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_fill = fill; req_tag = 12'(t);
        req_perm = 2'(pm); req_comp = c; req_size = 4'(sz);
        @(negedge clk);
        req_valid = 1'b0;
        if (fill) begin
            flag("R11 ready low after fill", req_ready == 1'b0, int'(req_ready), 0);
            while (!rsp_valid) @(negedge clk);
        end
    endtask

    task automatic lookup(int t);
        int i, h, p, c, pm, sz, st;
        string lbl;
        issue(1'b0, t, 0, 1'b0, 0);
        i = find(t);
        if (i < 0) begin
            lbl = "R4 R1 unknown tag"; h = 0; p = 0; c = 0; pm = 0; sz = 0; st = 0;
        end else begin
            h = m_pres[i]; p = pos_of(i); c = m_comp[i]; pm = m_perm[i]; sz = m_size[i];
            st = (h != 0) ? start_of(i) : 0;
            lbl = (h != 0) ? "R2 R6 R9 hit" : "R3 R9 tag without data";
            touch(i);
        end
        check_one(lbl, t, h, (i >= 0) ? 1 : 0, p, c, pm, sz, st);
        @(negedge clk);
        flag("R11 single pulse", rsp_valid == 1'b0, int'(rsp_valid), 0);
    endtask

    task automatic fill(int t, int pm, bit c, int sz);
        int esz, i, tgt, found;
        esz = (!c || sz == 0 || sz > 8) ? 8 : sz;
        i = find(t);
        found = (i >= 0) ? 1 : 0;
        if (i >= 0) tgt = i;
        else begin
            tgt = -1;
            for (int k = 3; k >= 0; k--) if (m_valid[k] == 0) tgt = k;
            if (tgt < 0) tgt = m_ord[3];
        end
        m_pres[tgt] = 0; m_valid[tgt] = 0;
        while (used_segs() + esz > 16) begin
            for (int q = 3; q >= 0; q--)
                if (m_pres[m_ord[q]] != 0 && m_ord[q] != tgt) begin
                    m_pres[m_ord[q]] = 0;
                    break;
                end
        end
        m_valid[tgt] = 1; m_pres[tgt] = 1; m_tag[tgt] = t; m_perm[tgt] = pm;
        m_comp[tgt] = c; m_size[tgt] = esz;
        touch(tgt);
        issue(1'b1, t, pm, c, sz);
        check_one("R10 R5 R7 R8 fill", t, 0, found, 0, c, pm, esz, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 0; m_pres[i] = 0; m_tag[i] = 0; m_perm[i] = 0;
            m_comp[i] = 0; m_size[i] = 0; m_ord[i] = i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        flag("R1 ready after reset", req_ready == 1'b1, int'(req_ready), 1);
        flag("R1 no response after reset", rsp_valid == 1'b0, int'(rsp_valid), 0);
        lookup(7);

        // Directed: four lines whose total exceeds the pool
        fill(4, 1, 1'b1, 4);
        fill(3, 2, 1'b1, 6);
        fill(2, 3, 1'b1, 2);
        fill(1, 0, 1'b0, 3);   // R5: uncompressed -> 8 segments, evicts tag 4 data
        for (int t = 0; t < 6; t++) lookup(t);
        fill(5, 1, 1'b1, 0);   // R5: size 0 -> 8
        fill(6, 2, 1'b1, 8);   // R8: reclaim LRU tag
        for (int t = 0; t < 7; t++) lookup(t);

        // Sweep
        lf = 16'hACE1;
        for (int r = 0; r < 300; r++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            fill(int'(lf[2:0]) % 6, int'(lf[4:3]), lf[5], int'(lf[9:6]));
            for (int t = 0; t < 6; t++) lookup(t);
            lookup(4095);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule